// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Port

This block is the programming front end of a frequency synthesizer. A host shifts 18-bit frames in over three wires: a serial clock, a data line and a latch strobe. The last bit of each frame chooses which of two 17-bit control words the latch strobe updates. The reference word holds the reference-buffer option, the lock-output select, the phase polarity, the charge-pump high-impedance bit and the reference divide count. The feedback word holds the B and A divide counts and a two-bit power mode. All three wires are sampled on the system clock. A rising edge on the serial clock or on the strobe counts as an event on the cycle where it is first seen.

The block also contains the power controller. It combines the chip-enable input with the programmed power mode. It drives a block-enable output for the analog sections, a divider-hold output and a charge-pump high-impedance output. Power-down can be immediate. It can also be deferred until the current charge-pump pulse ends. The power controller has five states:
- `ST_RUN`: normal operation.
- `ST_SYNC_WAIT`: waiting for a pump pulse to end.
- `ST_DOWN`: powered down.
- `ST_WAKE`: timed bias settling with the dividers still held.
- `ST_CNT_RST`: dividers held with the blocks on.

Its transitions are:
- From `ST_RUN`: a deferred request goes to `ST_SYNC_WAIT`, a divider-reset request to `ST_CNT_RST`, and an immediate request to `ST_DOWN`.
- From `ST_SYNC_WAIT`: a falling edge of `pump_active` goes to `ST_DOWN`.
- From `ST_DOWN`: normal mode goes to `ST_WAKE`.
- From `ST_WAKE`: expiry of the wake counter goes to `ST_RUN`.
- From `ST_CNT_RST`: normal mode goes straight to `ST_RUN`.
- From any state: an immediate request goes to `ST_DOWN` and a divider-reset request goes to `ST_CNT_RST`.
- From `ST_WAKE` or `ST_CNT_RST`: a deferred request goes to `ST_DOWN`, because the held dividers produce no pump pulse.

Top module: `synth_cfg_port`

## Requirements
- R1: A rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 18-bit frame, and the older bits move one place toward bit 17. The first bit sent therefore ends in bit 17.
- R2: A rising edge of `ser_latch` copies frame bits 17:1 into the reference word when frame bit 0 is 1, and into the feedback word when it is 0. The new values show on the outputs one system clock after the strobe edge is sampled. The word that was not selected keeps its value.
- R3: Reference-word fields by frame bit: 17:15 `ref_opt`, 14:13 `ld_sel`, 12 `phase_pol`, 11 charge-pump high-impedance bit, 10:1 `ref_count`.
- R4: Feedback-word fields by frame bit: 17:8 `b_count`, 7:3 `a_count`, 2:1 `pwr_mode`. The mode codes are 0 normal, 1 deferred power-down, 2 divider reset and 3 immediate power-down.
- R5: After reset, every field is zero, `blocks_on` is 1, `div_hold` is 0 and `cp_hiz` is 0.
- R6: Mode 3, or `chip_en` low whatever the mode, forces `blocks_on` to 0 and `div_hold` to 1 at once, with no clock edge needed.
- R7: With mode 1, `blocks_on` stays 1 until a falling edge of `pump_active` is seen. `blocks_on` drops on the clock edge that samples `pump_active` low after it was high.
- R8: On return to mode 0 from power-down, the controller enters `ST_WAKE` one clock later with `blocks_on` = 1. `div_hold` stays 1 for `WAKE_CYCLES` clocks in `ST_WAKE`. It is then released.
- R9: Mode 2 raises `div_hold` at once and keeps `blocks_on` at 1. On return to mode 0, `div_hold` is released on the next clock edge, with no wake delay.
- R10: `cp_hiz` is 1 whenever the stored high-impedance bit is 1 or `blocks_on` is 0. It follows either cause with no extra register.
- R11: Frames are shifted and latched normally while powered down.
- R12: Shifting a frame without a strobe edge changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_data | input | 1 | Serial data, first bit ends as frame bit 17 |
| ser_latch | input | 1 | Latch strobe; a rising edge stores the frame |
| chip_en | input | 1 | Chip enable; low forces immediate power-down |
| pump_active | input | 1 | High while a charge-pump pulse is in progress |
| ref_opt | output | 3 | Reference-buffer option field |
| ld_sel | output | 2 | Lock-output select field |
| phase_pol | output | 1 | Phase-detector polarity |
| ref_count | output | 10 | Reference divide count |
| b_count | output | 10 | Feedback B count |
| a_count | output | 5 | Feedback A (swallow) count |
| pwr_mode | output | 2 | Stored power-mode code |
| blocks_on | output | 1 | Enable for the analog blocks |
| div_hold | output | 1 | Holds both dividers at their load point |
| cp_hiz | output | 1 | Charge-pump output to high impedance |

## Verification
Inputs change on falling edges, so a strobe is sampled at the next rising edge. The stored fields, the immediate-mode overrides and `cp_hiz` are checked at the first falling edge after that rising edge. Effects that need a controller state change are checked one falling edge later:
- `blocks_on` returning during wake-up.
- The divider release after a divider reset.
- The deferred power-down after the pump falls.

The same check confirms they had not moved one sample earlier. The wake-up hold is measured by counting falling-edge samples with `div_hold` high. The count is `WAKE_CYCLES` + 1 after a strobe, since the controller spends one clock in `ST_DOWN` first. It is exactly `WAKE_CYCLES` after a `chip_en` rise, because `chip_en` enters the next-state logic directly.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int FRAME_W = 18;
    localparam int BODY_W  = FRAME_W - 1;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_SYNC   = 2'd1,
        PM_CRST   = 2'd2,
        PM_ASYNC  = 2'd3
    } pwr_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SYNC_WAIT,
        ST_DOWN,
        ST_WAKE,
        ST_CNT_RST
    } pwr_state_e;

    // reference word, packed from frame bit 17 down to bit 1
    typedef struct packed {
        logic [2:0] ref_opt;
        logic [1:0] ld_sel;
        logic       phase_pol;
        logic       cp_tri;
        logic [9:0] ref_cnt;
    } rword_t;

    // feedback word, packed from frame bit 17 down to bit 1
    typedef struct packed {
        logic [9:0] b_cnt;
        logic [4:0] a_cnt;
        pwr_mode_e  pmode;
    } nword_t;

endpackage

// File: rtl/cfgport_shift.sv
module cfgport_shift #(
    parameter int FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_latch,
    output logic [FRAME_W-1:0] frame,
    output logic               load_stb
);

    logic sclk_q;
    logic latch_q;
    logic sclk_rise;

    assign sclk_rise = ser_clk & ~sclk_q;
    assign load_stb  = ser_latch & ~latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
            frame   <= '0;
        end else begin
            sclk_q  <= ser_clk;
            latch_q <= ser_latch;
            if (sclk_rise) begin
                frame <= {frame[FRAME_W-2:0], ser_data};
            end
        end
    end

    // R1: the newest bit lands in bit 0
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> frame[0] == $past(ser_data));

    // R12: no serial edge, no frame change
    p_frame_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(frame));

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame,
    input  logic               load_stb,
    output rword_t             r_q,
    output nword_t             n_q
);

    logic sel_r;

    assign sel_r = frame[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            n_q <= '0;
        end else if (load_stb) begin
            if (sel_r) begin
                r_q <= rword_t'(frame[FRAME_W-1:1]);
            end else begin
                n_q <= nword_t'(frame[FRAME_W-1:1]);
            end
        end
    end

    // R2: a reference load leaves the feedback word alone, and the reverse
    p_r_load_keeps_n_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && sel_r) |=> $stable(n_q));
    p_n_load_keeps_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !sel_r) |=> $stable(r_q));
    // R12: no strobe, no change
    p_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> ($stable(r_q) && $stable(n_q)));

endmodule

// File: rtl/cfgport_power.sv
module cfgport_power
    import cfgport_pkg::*;
#(
    parameter int WAKE_CYCLES = 75
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chip_en,
    input  pwr_mode_e mode_field,
    input  logic      pump_active,
    output logic      blocks_on,
    output logic      div_hold
);

    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

    pwr_state_e    state;
    pwr_state_e    state_n;
    pwr_mode_e     mode_eff;
    logic          pump_q;
    logic          pump_done;
    logic [CW-1:0] wake_cnt;

    assign mode_eff  = chip_en ? mode_field : PM_ASYNC;
    assign pump_done = pump_q & ~pump_active;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_RUN: begin
                unique case (mode_eff)
                    PM_SYNC:  state_n = ST_SYNC_WAIT;
                    PM_CRST:  state_n = ST_CNT_RST;
                    PM_ASYNC: state_n = ST_DOWN;
                    default:  state_n = ST_RUN;
                endcase
            end
            ST_SYNC_WAIT: begin
                unique case (mode_eff)
                    PM_NORMAL: state_n = ST_RUN;
                    PM_CRST:   state_n = ST_CNT_RST;
                    PM_ASYNC:  state_n = ST_DOWN;
                    default:   state_n = pump_done ? ST_DOWN : ST_SYNC_WAIT;
                endcase
            end
            ST_DOWN: begin
                unique case (mode_eff)
                    PM_NORMAL: state_n = ST_WAKE;
                    PM_CRST:   state_n = ST_CNT_RST;
                    default:   state_n = ST_DOWN;
                endcase
            end
            ST_WAKE: begin
                unique case (mode_eff)
                    PM_NORMAL: state_n = (wake_cnt == WAKE_LAST) ? ST_RUN : ST_WAKE;
                    PM_CRST:   state_n = ST_CNT_RST;
                    default:   state_n = ST_DOWN;
                endcase
            end
            ST_CNT_RST: begin
                unique case (mode_eff)
                    PM_NORMAL: state_n = ST_RUN;
                    PM_CRST:   state_n = ST_CNT_RST;
                    default:   state_n = ST_DOWN;
                endcase
            end
            default: state_n = ST_RUN;
        endcase
    end

    // state register, pump history and wake counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            pump_q   <= 1'b0;
            wake_cnt <= '0;
        end else begin
            state  <= state_n;
            pump_q <= pump_active;
            if (state == ST_WAKE) begin
                wake_cnt <= wake_cnt + 1'b1;
            end else begin
                wake_cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        blocks_on = 1'b1;
        div_hold  = 1'b0;
        unique case (state)
            ST_RUN, ST_SYNC_WAIT: begin
                blocks_on = 1'b1;
                div_hold  = 1'b0;
            end
            ST_DOWN: begin
                blocks_on = 1'b0;
                div_hold  = 1'b1;
            end
            ST_WAKE, ST_CNT_RST: begin
                blocks_on = 1'b1;
                div_hold  = 1'b1;
            end
            default: begin
                blocks_on = 1'b1;
                div_hold  = 1'b0;
            end
        endcase
        if (mode_eff == PM_ASYNC) begin
            blocks_on = 1'b0;
            div_hold  = 1'b1;
        end else if (mode_eff == PM_CRST) begin
            div_hold = 1'b1;
        end
    end

    // R6: powered-down blocks always have their dividers held
    p_off_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !blocks_on |-> div_hold);
    // R7: without a completed pump pulse the deferred request keeps waiting
    p_sync_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC_WAIT && !pump_done && mode_eff == PM_SYNC) |=> state == ST_SYNC_WAIT);
    // R8: the wake counter stays inside its window and releases on its last count
    p_wake_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (wake_cnt <= WAKE_LAST));
    p_wake_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && wake_cnt == WAKE_LAST && mode_eff == PM_NORMAL) |=> state == ST_RUN);
    // R9: divider reset returns to normal in one clock
    p_crst_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CNT_RST && mode_eff == PM_NORMAL) |=> (state == ST_RUN && !div_hold));

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import cfgport_pkg::*;
#(
    parameter int WAKE_CYCLES = 75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_latch,
    input  logic       chip_en,
    input  logic       pump_active,
    output logic [2:0] ref_opt,
    output logic [1:0] ld_sel,
    output logic       phase_pol,
    output logic [9:0] ref_count,
    output logic [9:0] b_count,
    output logic [4:0] a_count,
    output logic [1:0] pwr_mode,
    output logic       blocks_on,
    output logic       div_hold,
    output logic       cp_hiz
);

    logic [FRAME_W-1:0] frame;
    logic               load_stb;
    rword_t             r_q;
    nword_t             n_q;

    cfgport_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .frame     (frame),
        .load_stb  (load_stb)
    );

    cfgport_regs #(.FRAME_W(FRAME_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame    (frame),
        .load_stb (load_stb),
        .r_q      (r_q),
        .n_q      (n_q)
    );

    cfgport_power #(.WAKE_CYCLES(WAKE_CYCLES)) u_power (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_en     (chip_en),
        .mode_field  (n_q.pmode),
        .pump_active (pump_active),
        .blocks_on   (blocks_on),
        .div_hold    (div_hold)
    );

    assign ref_opt   = r_q.ref_opt;
    assign ld_sel    = r_q.ld_sel;
    assign phase_pol = r_q.phase_pol;
    assign ref_count = r_q.ref_cnt;
    assign b_count   = n_q.b_cnt;
    assign a_count   = n_q.a_cnt;
    assign pwr_mode  = n_q.pmode;
    assign cp_hiz    = r_q.cp_tri | ~blocks_on;

    // R10: a disabled pump is never left driving
    p_off_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !blocks_on |-> cp_hiz);
    // R6: chip enable low forces power-down
    p_ce_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (!blocks_on && div_hold));

endmodule

// File: tb/synth_cfg_port_tb_top.sv
module synth_cfg_port_tb_top;

    localparam int W = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_latch = 1'b0;
    logic       chip_en = 1'b1;
    logic       pump_active = 1'b0;
    logic [2:0] ref_opt;
    logic [1:0] ld_sel;
    logic       phase_pol;
    logic [9:0] ref_count;
    logic [9:0] b_count;
    logic [4:0] a_count;
    logic [1:0] pwr_mode;
    logic       blocks_on;
    logic       div_hold;
    logic       cp_hiz;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    synth_cfg_port #(.WAKE_CYCLES(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .chip_en(chip_en), .pump_active(pump_active),
        .ref_opt(ref_opt), .ld_sel(ld_sel), .phase_pol(phase_pol),
        .ref_count(ref_count), .b_count(b_count), .a_count(a_count),
        .pwr_mode(pwr_mode), .blocks_on(blocks_on), .div_hold(div_hold),
        .cp_hiz(cp_hiz)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] mk_r(input logic [2:0] opt, input logic [1:0] ld,
                                         input logic pol, input logic tri_b,
                                         input logic [9:0] rc);
        return {opt, ld, pol, tri_b, rc, 1'b1};
    endfunction

    function automatic logic [17:0] mk_n(input logic [9:0] b, input logic [4:0] a,
                                         input logic [1:0] pd);
        return {b, a, pd, 1'b0};
    endfunction

    task automatic shift_frame(input logic [17:0] f);
        for (int i = 17; i >= 0; i--) begin
            @(negedge clk);
            ser_data = f[i];
            ser_clk  = 1'b1;
            @(negedge clk);
            ser_clk  = 1'b0;
        end
    endtask

    // returns at the first falling edge after the strobe is sampled
    task automatic send_frame(input logic [17:0] f);
        shift_frame(f);
        @(negedge clk);
        ser_latch = 1'b1;
        @(negedge clk);
        ser_latch = 1'b0;
    endtask

    task automatic t_reset();
        chk("R5 ref_opt", ref_opt, 0);
        chk("R5 ref_count", ref_count, 0);
        chk("R5 b_count", b_count, 0);
        chk("R5 pwr_mode", pwr_mode, 0);
        chk("R5 blocks_on", blocks_on, 1);
        chk("R5 div_hold", div_hold, 0);
        chk("R5 cp_hiz", cp_hiz, 0);
    endtask

    task automatic t_rload();
        send_frame(mk_r(3'd5, 2'd2, 1'b1, 1'b0, 10'h2A5));
        chk("R3 ref_opt", ref_opt, 5);
        chk("R3 ld_sel", ld_sel, 2);
        chk("R3 phase_pol", phase_pol, 1);
        chk("R1 R3 ref_count", ref_count, 'h2A5);
        chk("R3 cp_hiz", cp_hiz, 0);
        chk("R2 b_count kept", b_count, 0);
        chk("R2 a_count kept", a_count, 0);
    endtask

    task automatic t_nload();
        send_frame(mk_n(10'h3C7, 5'h15, 2'd0));
        chk("R4 b_count", b_count, 'h3C7);
        chk("R4 a_count", a_count, 'h15);
        chk("R4 pwr_mode", pwr_mode, 0);
        chk("R2 ref_count kept", ref_count, 'h2A5);
        chk("R2 ref_opt kept", ref_opt, 5);
    endtask

    task automatic t_no_latch();
        shift_frame(mk_r(3'd2, 2'd1, 1'b0, 1'b1, 10'h011));
        repeat (3) @(negedge clk);
        chk("R12 ref_count", ref_count, 'h2A5);
        chk("R12 cp_hiz", cp_hiz, 0);
        chk("R12 ld_sel", ld_sel, 2);
    endtask

    task automatic t_tri();
        send_frame(mk_r(3'd5, 2'd2, 1'b1, 1'b1, 10'h2A5));
        chk("R10 cp_hiz set", cp_hiz, 1);
        chk("R10 blocks_on", blocks_on, 1);
        send_frame(mk_r(3'd5, 2'd2, 1'b1, 1'b0, 10'h2A5));
        chk("R10 cp_hiz clear", cp_hiz, 0);
    endtask

    task automatic t_async_wake();
        int h;
        send_frame(mk_n(10'h100, 5'h3, 2'd3));
        chk("R6 blocks_on", blocks_on, 0);
        chk("R6 div_hold", div_hold, 1);
        chk("R10 cp_hiz off", cp_hiz, 1);
        send_frame(mk_r(3'd7, 2'd3, 1'b0, 1'b0, 10'h155));
        chk("R11 ref_count", ref_count, 'h155);
        chk("R11 ref_opt", ref_opt, 7);
        chk("R11 still off", blocks_on, 0);
        send_frame(mk_n(10'h100, 5'h3, 2'd0));
        chk("R8 first sample off", blocks_on, 0);
        chk("R8 first sample hold", div_hold, 1);
        @(negedge clk);
        chk("R8 wake on", blocks_on, 1);
        chk("R8 wake hold", div_hold, 1);
        h = 2;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!div_hold) break;
            h++;
        end
        chk("R8 hold samples", h, W + 1);
        chk("R8 on after wake", blocks_on, 1);
    endtask

    task automatic t_chip_en();
        int h;
        @(negedge clk);
        chip_en = 1'b0;
        #1;
        chk("R6 ce low off", blocks_on, 0);
        chk("R6 ce low hold", div_hold, 1);
        repeat (3) @(negedge clk);
        chip_en = 1'b1;
        h = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!div_hold) break;
            h++;
        end
        chk("R8 ce wake samples", h, W);
    endtask

    task automatic t_sync();
        send_frame(mk_n(10'h100, 5'h3, 2'd1));
        chk("R7 on after request", blocks_on, 1);
        repeat (4) @(negedge clk);
        chk("R7 on without pulse", blocks_on, 1);
        pump_active = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 on during pulse", blocks_on, 1);
        pump_active = 1'b0;
        #1;
        chk("R7 on at pulse end", blocks_on, 1);
        @(negedge clk);
        chk("R7 off after pulse", blocks_on, 0);
        chk("R7 hold after pulse", div_hold, 1);
        send_frame(mk_n(10'h100, 5'h3, 2'd0));
        repeat (W + 4) @(negedge clk);
        chk("R8 back on", blocks_on, 1);
        chk("R8 released", div_hold, 0);
    endtask

    task automatic t_crst();
        send_frame(mk_n(10'h100, 5'h3, 2'd2));
        chk("R9 hold at once", div_hold, 1);
        chk("R9 stays on", blocks_on, 1);
        repeat (3) @(negedge clk);
        chk("R9 hold kept", div_hold, 1);
        send_frame(mk_n(10'h100, 5'h3, 2'd0));
        chk("R9 hold one clock", div_hold, 1);
        @(negedge clk);
        chk("R9 released", div_hold, 0);
        chk("R9 on", blocks_on, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rload();
        t_nload();
        t_no_latch();
        t_tri();
        t_async_wake();
        t_chip_en();
        t_sync();
        t_crst();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule